// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Unit

This block watches 32 general-purpose input pins and turns their activity into a single interrupt request for a host processor. The pins are handled as two halves of 16. Each half has its own set of 16-bit registers, so a 16-bit host bus can reach every control in one access. For each pin, software picks the following:
- level or edge sensing;
- which polarity counts as active;
- whether a detected edge is held until software clears it, or only reported while it happens;
- which edge directions count.

Pin inputs are asynchronous and first pass through a two-flop synchroniser. An edge is the difference between the current synchronised sample and the one before it. Each half has a pending status word. Software clears a status bit by writing a 1 to it. The status is gated by a per-pin enable word, and the result of both halves is ORed into the interrupt output. Register reads are combinational from the address. Writes take effect on the clock edge on which the write strobe is high.

Top module: `gpio_irq_unit`

## Requirements
- R1: The registers are 16 bits wide. Their byte offsets (low half / high half) are: pending status 0x08/0x0A, enable 0x0C/0x0E, sense type 0x10/0x12, polarity 0x14/0x16, hold select 0x18/0x1A, falling-edge select 0x20/0x22, rising-edge select 0x24/0x26. Each configuration register reads back what was last written to it. Any other offset reads 0, and writes to it change nothing.
- R2: Pin n with n<16 maps to bit n of the low-half registers. Pin n with n>=16 maps to bit n-16 of the high-half registers. An event on a high-half pin leaves the low-half status unchanged.
- R3: A sense-type bit of 0 selects level sensing. In that mode the status bit follows the pin's active condition. A polarity bit of 1 means the pin is active when high, and 0 means active when low. A change on the pin shows in status after the third rising clock edge following the change.
- R4: A sense-type bit of 1 selects edge sensing. With a hold-select bit of 1, a selected edge sets the status bit, and the bit stays set until a 1 is written to it. Writing 0 to a status bit has no effect.
- R5: With edge sensing and a hold-select bit of 0, each selected edge makes the status bit read 1 for exactly one clock cycle.
- R6: Falling-edge select 1 with rising-edge select 0 detects only falling edges. Falling 0 with rising 1 detects only rising edges. Both bits 1 detects both directions. Both bits 0 detects no edge.
- R7: If a selected edge and a write of 1 to the same held status bit fall on the same clock edge, the bit stays set.
- R8: In level mode, writing 1 to a status bit whose pin is still active leaves the bit reading 1 after that write.
- R9: irq_o is high exactly when status AND enable is nonzero in either half. A half whose enable bits are 0 never drives irq_o.
- R10: After reset, all configuration registers (including both enable words) are 0, status is 0, and irq_o is low until pins raise pending bits that are also enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous general-purpose pin inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench makes a new edge arrive on the same clock edge as a write-1 clear of a held bit. A design that lets the clear win would silently lose that interrupt. It clears a level-sensed bit while its pin is still active, to catch a status that stays low although the condition persists. It also writes zeros to pending bits, which a design that treats the write as a plain store would wipe. Through-mode pulses are sampled on the cycle they appear and on the cycle after, to catch a pulse that sticks. Edges are driven against each selection pattern, including "no edge selected", and on a high-half pin with only the low enable set. These expose a swapped direction select, a wrong half mapping, or an interrupt that ignores its enable.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int HALF_W = 16;
  localparam int ADDR_W = 6;

  // low-half offsets; the high half sits one 16-bit word above each
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_EN   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_TYP  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_ACT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_HOLD = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_FALL = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE = 6'h24;
  localparam int HALF_STEP = 2;

  typedef struct packed {
    logic [HALF_W-1:0] en;
    logic [HALF_W-1:0] typ;   // 1: edge, 0: level
    logic [HALF_W-1:0] act;   // 1: active high
    logic [HALF_W-1:0] hold;  // 1: latch edge events
    logic [HALF_W-1:0] fall;
    logic [HALF_W-1:0] rise;
  } half_cfg_t;

  function automatic logic [ADDR_W-1:0] half_addr(input logic [ADDR_W-1:0] base, input int half);
    return base + ADDR_W'(half * HALF_STEP);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int HALF = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output half_cfg_t         cfg_o,
  output logic [HALF_W-1:0] clr_o
);
  localparam logic [ADDR_W-1:0] A_STAT = half_addr(OFF_STAT, HALF);
  localparam logic [ADDR_W-1:0] A_EN   = half_addr(OFF_EN, HALF);
  localparam logic [ADDR_W-1:0] A_TYP  = half_addr(OFF_TYP, HALF);
  localparam logic [ADDR_W-1:0] A_ACT  = half_addr(OFF_ACT, HALF);
  localparam logic [ADDR_W-1:0] A_HOLD = half_addr(OFF_HOLD, HALF);
  localparam logic [ADDR_W-1:0] A_FALL = half_addr(OFF_FALL, HALF);
  localparam logic [ADDR_W-1:0] A_RISE = half_addr(OFF_RISE, HALF);

  half_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_EN:    cfg_q.en   <= wdata_i;
        A_TYP:   cfg_q.typ  <= wdata_i;
        A_ACT:   cfg_q.act  <= wdata_i;
        A_HOLD:  cfg_q.hold <= wdata_i;
        A_FALL:  cfg_q.fall <= wdata_i;
        A_RISE:  cfg_q.rise <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign clr_o = (we_i && addr_i == A_STAT) ? wdata_i : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] s_i,
  input  half_cfg_t         cfg_i,
  input  logic [HALF_W-1:0] clr_i,
  output logic [HALF_W-1:0] st_o
);
  logic [HALF_W-1:0] prev_q, st_q, st_d;

  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    logic rise_hit, fall_hit, evt, lvl_hit;
    assign rise_hit = s_i[b] & ~prev_q[b] & cfg_i.rise[b];
    assign fall_hit = ~s_i[b] & prev_q[b] & cfg_i.fall[b];
    assign evt      = rise_hit | fall_hit;
    assign lvl_hit  = ~(s_i[b] ^ cfg_i.act[b]);

    always_comb begin
      if (!cfg_i.typ[b])      st_d[b] = lvl_hit;
      else if (cfg_i.hold[b]) st_d[b] = evt | (st_q[b] & ~clr_i[b]);  // new event beats clear
      else                    st_d[b] = evt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      st_q   <= '0;
    end else begin
      prev_q <= s_i;
      st_q   <= st_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [HALF_W-1:0]   reg_wdata_i,
  output logic [HALF_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int NUM_HALVES = NUM_PINS / HALF_W;

  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] st_all, en_all, typ_all, act_all, hold_all, fall_all, rise_all;
  half_cfg_t           cfg [NUM_HALVES];
  logic [HALF_W-1:0]   clr [NUM_HALVES];
  logic [HALF_W-1:0]   st  [NUM_HALVES];

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    gpio_irq_cfg #(.HALF(h)) u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i),
      .addr_i (reg_addr_i),
      .wdata_i(reg_wdata_i),
      .cfg_o  (cfg[h]),
      .clr_o  (clr[h])
    );

    gpio_irq_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .s_i   (pin_s[h*HALF_W +: HALF_W]),
      .cfg_i (cfg[h]),
      .clr_i (clr[h]),
      .st_o  (st[h])
    );

    assign st_all  [h*HALF_W +: HALF_W] = st[h];
    assign en_all  [h*HALF_W +: HALF_W] = cfg[h].en;
    assign typ_all [h*HALF_W +: HALF_W] = cfg[h].typ;
    assign act_all [h*HALF_W +: HALF_W] = cfg[h].act;
    assign hold_all[h*HALF_W +: HALF_W] = cfg[h].hold;
    assign fall_all[h*HALF_W +: HALF_W] = cfg[h].fall;
    assign rise_all[h*HALF_W +: HALF_W] = cfg[h].rise;
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (reg_addr_i == half_addr(OFF_STAT, h)) reg_rdata_o = st[h];
      if (reg_addr_i == half_addr(OFF_EN, h))   reg_rdata_o = cfg[h].en;
      if (reg_addr_i == half_addr(OFF_TYP, h))  reg_rdata_o = cfg[h].typ;
      if (reg_addr_i == half_addr(OFF_ACT, h))  reg_rdata_o = cfg[h].act;
      if (reg_addr_i == half_addr(OFF_HOLD, h)) reg_rdata_o = cfg[h].hold;
      if (reg_addr_i == half_addr(OFF_FALL, h)) reg_rdata_o = cfg[h].fall;
      if (reg_addr_i == half_addr(OFF_RISE, h)) reg_rdata_o = cfg[h].rise;
    end
  end

  assign irq_o = |(st_all & en_all);
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [HALF_W-1:0]   wdata_i,
  input logic [NUM_PINS-1:0] sync_i,
  input logic [NUM_PINS-1:0] st_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic [NUM_PINS-1:0] typ_i,
  input logic [NUM_PINS-1:0] act_i,
  input logic [NUM_PINS-1:0] hold_i,
  input logic [NUM_PINS-1:0] fall_i,
  input logic [NUM_PINS-1:0] rise_i,
  input logic                irq_i
);
  localparam int NUM_HALVES = NUM_PINS / HALF_W;

  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] keep_q, lvl_q, act_q, idle_q, st_q;

  always_comb begin
    clr_w = '0;
    for (int h = 0; h < NUM_HALVES; h++)
      if (we_i && addr_i == half_addr(OFF_STAT, h)) clr_w[h*HALF_W +: HALF_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= '0;
      lvl_q  <= '0;
      act_q  <= '0;
      idle_q <= '0;
      st_q   <= '0;
    end else begin
      keep_q <= st_i & typ_i & hold_i & ~clr_w;
      lvl_q  <= ~typ_i;
      act_q  <= ~(sync_i ^ act_i);
      idle_q <= typ_i & ~fall_i & ~rise_i;
      st_q   <= st_i;
    end
  end

  // R4: held bit survives unless written with 1
  p_hold_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_q & ~st_i) == '0);

  // R3: level-sensed status tracks the synchronised active condition
  p_level_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q & (st_i ^ act_q)) == '0);

  // R6: edge pins with no direction selected never rise in status
  p_no_idle_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q & st_i & ~st_q) == '0);

  // R9: nothing enabled, no request
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_i);
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (reg_we_i),
  .addr_i (reg_addr_i),
  .wdata_i(reg_wdata_i),
  .sync_i (pin_s),
  .st_i   (st_all),
  .en_i   (en_all),
  .typ_i  (typ_all),
  .act_i  (act_all),
  .hold_i (hold_all),
  .fall_i (fall_all),
  .rise_i (rise_all),
  .irq_i  (irq_o)
);

// File: tb/tb_gpio_irq_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_unit;
  localparam logic [5:0] A_ST_L = 6'h08, A_ST_H = 6'h0A, A_EN_L = 6'h0C, A_EN_H = 6'h0E;
  localparam logic [5:0] A_TY_L = 6'h10, A_TY_H = 6'h12, A_AC_L = 6'h14, A_AC_H = 6'h16;
  localparam logic [5:0] A_HO_L = 6'h18, A_HO_H = 6'h1A, A_FA_L = 6'h20, A_FA_H = 6'h22;
  localparam logic [5:0] A_RI_L = 6'h24, A_RI_H = 6'h26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  gpio_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [5:0]  a;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_total = 0, n_fail = 0;
  bit    done = 1'b0;

  // monitor
  initial begin
    forever begin
      item_t it;
      logic [15:0] got;
      @(chk_ev);
      #0.1;
      it = q.pop_front();
      got = it.is_irq ? {15'd0, irq} : rdata;
      n_total++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, got, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    addr = a;
    q.push_back('{1'b0, a, e, tag});
    ->chk_ev;
    #0.2;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    q.push_back('{1'b1, 6'h00, {15'd0, e}, tag});
    ->chk_ev;
    #0.2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic drive(input int b, input logic v);
    @(negedge clk);
    pins[b] = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state before any clock edge
    chk_rd(A_EN_L, 16'h0000, "R10 en_lo");
    chk_rd(A_EN_H, 16'h0000, "R10 en_hi");
    chk_rd(A_TY_L, 16'h0000, "R10 typ_lo");
    chk_rd(A_HO_H, 16'h0000, "R10 hold_hi");
    chk_rd(A_ST_L, 16'h0000, "R10 status_lo");
    chk_irq(1'b0, "R10 irq");
    @(negedge clk);
    // R3: level, active-low, pins low -> all pending
    chk_rd(A_ST_L, 16'hFFFF, "R3 reset level lo");
    chk_rd(A_ST_H, 16'hFFFF, "R3 reset level hi");
    chk_irq(1'b0, "R9 irq gated by zero enable");

    // R1: readback
    wr(A_TY_L, 16'hFFFF); wr(A_TY_H, 16'hFFFF);
    wr(A_HO_L, 16'hFFFF); wr(A_HO_H, 16'hFFFF);
    wr(A_AC_L, 16'h00FF); wr(A_AC_H, 16'hFF00);
    wr(A_FA_L, 16'h1234); wr(A_FA_H, 16'h4321);
    wr(A_RI_L, 16'h8888); wr(A_RI_H, 16'h0101);
    wr(A_EN_L, 16'h0F0F); wr(A_EN_H, 16'hF00F);
    wr(6'h1C, 16'hBEEF);
    chk_rd(A_TY_L, 16'hFFFF, "R1 typ_lo");
    chk_rd(A_TY_H, 16'hFFFF, "R1 typ_hi");
    chk_rd(A_HO_L, 16'hFFFF, "R1 hold_lo");
    chk_rd(A_HO_H, 16'hFFFF, "R1 hold_hi");
    chk_rd(A_AC_L, 16'h00FF, "R1 act_lo");
    chk_rd(A_AC_H, 16'hFF00, "R1 act_hi");
    chk_rd(A_FA_L, 16'h1234, "R1 fall_lo");
    chk_rd(A_FA_H, 16'h4321, "R1 fall_hi");
    chk_rd(A_RI_L, 16'h8888, "R1 rise_lo");
    chk_rd(A_RI_H, 16'h0101, "R1 rise_hi");
    chk_rd(A_EN_L, 16'h0F0F, "R1 en_lo");
    chk_rd(A_EN_H, 16'hF00F, "R1 en_hi");
    chk_rd(6'h00, 16'h0000, "R1 unmapped 00");
    chk_rd(6'h1C, 16'h0000, "R1 unmapped 1C");
    wr(A_EN_L, 16'h0); wr(A_EN_H, 16'h0);
    wr(A_AC_L, 16'h0); wr(A_AC_H, 16'h0);
    wr(A_FA_L, 16'h0); wr(A_FA_H, 16'h0);
    wr(A_RI_L, 16'h0); wr(A_RI_H, 16'h0);
    wr(A_ST_L, 16'hFFFF); wr(A_ST_H, 16'hFFFF);
    chk_rd(A_ST_L, 16'h0000, "R4 cleared lo");
    chk_rd(A_ST_H, 16'h0000, "R4 cleared hi");
    chk_irq(1'b0, "R9 idle");

    // R4: rising, hold
    wr(A_RI_L, 16'h0008); wr(A_EN_L, 16'h0008);
    drive(3, 1'b1); settle();
    chk_rd(A_ST_L, 16'h0008, "R4 rise latched");
    chk_irq(1'b1, "R9 enabled pending");
    drive(3, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0008, "R4 held after fall");
    wr(A_ST_L, 16'h0000);
    chk_rd(A_ST_L, 16'h0008, "R4 write 0 ignored");
    wr(A_ST_L, 16'h0008);
    chk_rd(A_ST_L, 16'h0000, "R4 write 1 clears");
    chk_irq(1'b0, "R9 cleared");

    // R2: high half mapping
    wr(A_RI_H, 16'h0020);
    drive(21, 1'b1); settle();
    chk_rd(A_ST_H, 16'h0020, "R2 pin21 -> hi bit5");
    chk_rd(A_ST_L, 16'h0000, "R2 low untouched");
    chk_irq(1'b0, "R9 hi pending, hi disabled");
    wr(A_EN_H, 16'h0020);
    chk_irq(1'b1, "R9 hi enabled");
    wr(A_EN_H, 16'h0000);
    chk_irq(1'b0, "R9 hi disabled again");
    wr(A_ST_H, 16'h0020);
    chk_rd(A_ST_H, 16'h0000, "R2 hi cleared");

    // R6: edge direction
    wr(A_FA_L, 16'h0002);
    drive(1, 1'b1); settle();
    chk_rd(A_ST_L, 16'h0000, "R6 falling-only ignores rise");
    drive(1, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0002, "R6 falling-only sees fall");
    wr(A_ST_L, 16'h0002);
    wr(A_RI_L, 16'h000A);
    drive(1, 1'b1); settle();
    chk_rd(A_ST_L, 16'h0002, "R6 both sees rise");
    wr(A_ST_L, 16'h0002);
    drive(1, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0002, "R6 both sees fall");
    wr(A_ST_L, 16'h0002);
    chk_rd(A_ST_L, 16'h0000, "R6 cleared");
    drive(9, 1'b1); settle();
    drive(9, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0000, "R6 no select no event");

    // R5: through mode
    wr(A_HO_L, 16'hFFEF); wr(A_RI_L, 16'h001A); wr(A_EN_L, 16'h0010);
    drive(4, 1'b1); settle();
    chk_rd(A_ST_L, 16'h0010, "R5 pulse present");
    chk_irq(1'b1, "R5 irq pulse");
    @(negedge clk);
    chk_rd(A_ST_L, 16'h0000, "R5 pulse gone next cycle");
    chk_irq(1'b0, "R5 irq pulse gone");
    drive(4, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0000, "R5 unselected fall");

    // R7: event and clear on same edge
    drive(3, 1'b1);
    @(negedge clk);
    wr(A_ST_L, 16'h0008);
    chk_rd(A_ST_L, 16'h0008, "R7 event beats clear");
    wr(A_ST_L, 16'h0008);
    chk_rd(A_ST_L, 16'h0000, "R7 later clear works");
    drive(3, 1'b0); settle();

    // R3 / R8: level mode on pin 12
    wr(A_AC_L, 16'h1000); wr(A_TY_L, 16'hEFFF);
    @(negedge clk);
    chk_rd(A_ST_L, 16'h0000, "R3 active-high pin low");
    drive(12, 1'b1); settle();
    chk_rd(A_ST_L, 16'h1000, "R3 active-high pin high");
    wr(A_ST_L, 16'h1000);
    chk_rd(A_ST_L, 16'h1000, "R8 clear while active");
    drive(12, 1'b0); settle();
    chk_rd(A_ST_L, 16'h0000, "R3 follows release");
    wr(A_AC_L, 16'h0000);
    @(negedge clk);
    chk_rd(A_ST_L, 16'h1000, "R3 active-low pin low");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule